// File: doc/BRIEF.md
# Display Buffer Memory with Prefetched Readback

This block holds the byte-wide frame memory of a 128×64 monochrome graphics panel controller and gives a host access to it through a synchronous parallel port. The port has three single-cycle strobes. One loads the address counter, one writes a byte, and one reads a byte. An internal address counter steps forward after every write and every read, so the host can stream through memory after it sets the address once.

Reads go through a one-deep prefetch register. A read strobe returns the byte that an earlier read placed in that register. In the same cycle the block loads the byte at the current address into the register and steps the counter. Loading the address clears the prefetch register to zero. After any address change, the host therefore discards one dummy read before real data appears. Writes land in memory at once and do not touch the prefetch register.

Memory is stored as wide rows of several bytes. The counter picks a row and a byte lane within that row. Reset clears the counter, the prefetch register and the output, and leaves the memory contents as they are.

Top module: `pixel_buf_rdpipe`

## Requirements
- R1: After synchronous reset the address counter is 0, the prefetch register holds 0x00 and `rd_valid` is low, so a read issued straight after reset returns 0x00.
- R2: A set-address strobe loads the counter with `set_addr_val` and clears the prefetch register to 0x00. The first read after it returns 0x00.
- R3: A read strobe puts the old prefetch value on `rd_data`, loads the byte at the current address into the prefetch register and advances the counter by one. After a set-address to N, reads return 0x00, then the bytes at N, N+1, N+2 and so on.
- R4: A write strobe stores `wr_data` at the current address at once, so a later fetch of that address sees it. It then advances the counter by one and leaves the prefetch register unchanged.
- R5: The counter is 13 bits wide and wraps from 0x1FFF to 0x0000 on both reads and writes.
- R6: `rd_valid` is high for exactly the one cycle after a performed read, with `rd_data` registered in that same cycle. `rd_data` keeps its value while no read is performed.
- R7: When strobes coincide, set-address beats write and write beats read. The losing strobes have no effect that cycle: no memory change, no counter step and no `rd_valid` pulse.
- R8: Reset does not change the memory contents.
- R9: If 0xAA is written at address 0, the address is set to 0 and two reads follow, the reads return 0x00 and then 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_addr_stb | input | 1 | Load the address counter this cycle |
| set_addr_val | input | 13 | New counter value |
| wr_stb | input | 1 | Write `wr_data` at the counter this cycle |
| wr_data | input | 8 | Byte to store |
| rd_stb | input | 1 | Read request this cycle |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as new |

## Verification
Three pairs of operations can fall in the same cycle. The one that matters most is a write and a read at the same address, where the read must prefetch the old byte or the new one according to priority. The bench raises set-address, write and read together, and then write and read together, from a single negedge drive. It judges the result at the ports. `rd_valid` must stay low, and the memory bytes are read back afterwards to show that the losing write never landed and that the counter did not step. A separate sequence puts a write between a dummy read and a real read, which shows that the prefetched byte survives the write.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_SET  = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } pbr_op_e;

  // Next counter value with wrap over a power-of-two depth.
  function automatic int unsigned addr_step(int unsigned cur, int unsigned depth);
    return (cur + 1) % depth;
  endfunction

  // Row of the wide memory holding a byte address.
  function automatic int unsigned row_of(int unsigned a, int unsigned lanes);
    return a / lanes;
  endfunction

  // Byte lane inside a row.
  function automatic int unsigned lane_of(int unsigned a, int unsigned lanes);
    return a % lanes;
  endfunction

endpackage

// File: rtl/pbr_strobe_arb.sv
module pbr_strobe_arb
  import pbr_pkg::*;
(
  input  logic    set_stb,
  input  logic    wr_stb,
  input  logic    rd_stb,
  output pbr_op_e op,
  output logic    do_set,
  output logic    do_wr,
  output logic    do_rd
);

  always_comb begin
    if (set_stb)     op = OP_SET;
    else if (wr_stb) op = OP_WR;
    else if (rd_stb) op = OP_RD;
    else             op = OP_IDLE;
  end

  assign do_set = (op == OP_SET);
  assign do_wr  = (op == OP_WR);
  assign do_rd  = (op == OP_RD);

endmodule

// File: rtl/pbr_addr_ctr.sv
module pbr_addr_ctr
  import pbr_pkg::*;
#(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  pbr_op_e       op,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] addr_q
);

  logic [AW-1:0] addr_nx;

  assign addr_nx = AW'(addr_step(32'(addr_q), DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      unique case (op)
        OP_SET:       addr_q <= load_val;
        OP_WR, OP_RD: addr_q <= addr_nx;
        default:      addr_q <= addr_q;
      endcase
    end
  end

endmodule

// File: rtl/pbr_row_ram.sv
module pbr_row_ram
  import pbr_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int DATA_W = 8,
  parameter int LANES  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int ROWS  = DEPTH / LANES,
  localparam int RW    = $clog2(ROWS),
  localparam int LW    = $clog2(LANES),
  localparam int ROW_W = LANES * DATA_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rbyte
);

  logic [ROW_W-1:0]  rows [ROWS];
  logic [RW-1:0]     row_idx;
  logic [LW-1:0]     lane_idx;
  logic [ROW_W-1:0]  row_word;
  logic [DATA_W-1:0] lane_bytes [LANES];

  assign row_idx  = RW'(row_of(32'(addr), LANES));
  assign lane_idx = LW'(lane_of(32'(addr), LANES));

  // Write lands in the selected lane of the selected row.
  always_ff @(posedge clk) begin
    if (we) rows[row_idx][lane_idx*DATA_W +: DATA_W] <= wdata;
  end

  // Combinational fetch: row select, then lane mux.
  assign row_word = rows[row_idx];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bytes[l] = row_word[l*DATA_W +: DATA_W];
  end

  assign rbyte = lane_bytes[lane_idx];

endmodule

// File: rtl/pbr_read_pipe.sv
module pbr_read_pipe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] fetch_byte,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= load;
      if (clr) begin
        pend_q <= '0;
      end else if (load) begin
        rd_data <= pend_q;
        pend_q  <= fetch_byte;
      end
    end
  end

endmodule

// File: rtl/pixel_buf_rdpipe.sv
module pixel_buf_rdpipe
  import pbr_pkg::*;
#(
  parameter int DEPTH  = 8192,
  parameter int DATA_W = 8,
  parameter int LANES  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_addr_stb,
  input  logic [AW-1:0]     set_addr_val,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  pbr_op_e           op;
  logic              do_set;
  logic              do_wr;
  logic              do_rd;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] fetch_byte;
  logic [DATA_W-1:0] pend_q;

  pbr_strobe_arb u_arb (
    .set_stb (set_addr_stb),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .op      (op),
    .do_set  (do_set),
    .do_wr   (do_wr),
    .do_rd   (do_rd)
  );

  pbr_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (set_addr_val),
    .addr_q   (addr_q)
  );

  pbr_row_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LANES(LANES)) u_ram (
    .clk   (clk),
    .we    (do_wr),
    .addr  (addr_q),
    .wdata (wr_data),
    .rbyte (fetch_byte)
  );

  pbr_read_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .clr        (do_set),
    .load       (do_rd),
    .fetch_byte (fetch_byte),
    .pend_q     (pend_q),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

endmodule

// File: rtl/pbr_chk.sv
module pbr_chk #(
  parameter int AW     = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              set_addr_stb,
  input logic [AW-1:0]     set_addr_val,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              do_set,
  input logic              do_wr,
  input logic              do_rd,
  input logic [AW-1:0]     addr_q,
  input logic [DATA_W-1:0] pend_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (addr_q == '0 && pend_q == '0 && !rd_valid));

  // R2
  set_loads_chk: assert property (@(posedge clk) disable iff (rst)
    do_set |=> (addr_q == $past(set_addr_val) && pend_q == '0));

  // R3
  read_returns_pend_chk: assert property (@(posedge clk) disable iff (rst)
    do_rd |=> rd_data == $past(pend_q));

  // R4
  write_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    do_wr |=> pend_q == $past(pend_q));

  // R5
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (do_rd || do_wr) |=> addr_q == AW'($past(addr_q) + 1'b1));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    do_rd |=> rd_valid);

  // R6
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> (!rd_valid && $stable(rd_data)));

  // R7
  single_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_set, do_wr, do_rd}));

  // R7
  priority_chk: assert property (@(posedge clk) disable iff (rst)
    (set_addr_stb |-> do_set) and ((wr_stb && !set_addr_stb) |-> do_wr)
    and ((rd_stb && !wr_stb && !set_addr_stb) |-> do_rd));

endmodule

bind pixel_buf_rdpipe pbr_chk #(.AW(AW), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .set_addr_stb (set_addr_stb),
  .set_addr_val (set_addr_val),
  .wr_stb       (wr_stb),
  .rd_stb       (rd_stb),
  .rd_data      (rd_data),
  .rd_valid     (rd_valid),
  .do_set       (do_set),
  .do_wr        (do_wr),
  .do_rd        (do_rd),
  .addr_q       (addr_q),
  .pend_q       (pend_q)
);

// File: tb/sim_pixel_buf_rdpipe.sv
`timescale 1ns/1ps
module sim_pixel_buf_rdpipe;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_addr_stb = 1'b0;
  logic [12:0] set_addr_val = '0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_buf_rdpipe u0 (
    .clk          (clk),
    .rst          (rst),
    .set_addr_stb (set_addr_stb),
    .set_addr_val (set_addr_val),
    .wr_stb       (wr_stb),
    .wr_data      (wr_data),
    .rd_stb       (rd_stb),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_set(input logic [12:0] a);
    @(negedge clk); set_addr_stb = 1'b1; set_addr_val = a;
    @(negedge clk); set_addr_stb = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] v, output logic vl);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; v = rd_data; vl = rd_valid;
  endtask

  task automatic rd_expect(input string req, input logic [7:0] exp);
    logic [7:0] v; logic vl;
    do_rd(v, vl);
    chk(req, v, exp);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  // R1, R6: reset state, then a read without any address set
  task automatic t_reset();
    logic [7:0] v; logic vl;
    chk("R1 rd_valid after reset", {7'd0, rd_valid}, 8'h00);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    do_rd(v, vl);
    chk("R1 first read after reset", v, 8'h00);
    chk("R6 rd_valid pulse", {7'd0, vl}, 8'h01);
    @(negedge clk);
    chk("R6 rd_valid drops", {7'd0, rd_valid}, 8'h00);
  endtask

  // R9: the 0xAA dummy-read example
  task automatic t_aa();
    do_set(13'h0000);
    do_wr(8'hAA);
    do_set(13'h0000);
    rd_expect("R9 dummy read", 8'h00);
    rd_expect("R9 real read", 8'hAA);
  endtask

  // R2, R3: streaming readback with one dummy read
  task automatic t_stream();
    do_set(13'h0100);
    for (int i = 0; i < 16; i++) do_wr(pat(i));
    do_set(13'h0100);
    rd_expect("R2 dummy after set", 8'h00);
    for (int i = 0; i < 16; i++) rd_expect("R3 stream", pat(i));
  endtask

  // R4: write is immediate and leaves the prefetch intact
  task automatic t_write_pend();
    do_set(13'h0200);
    do_wr(8'h11); do_wr(8'h22); do_wr(8'h33);
    do_set(13'h0200);
    rd_expect("R4 dummy", 8'h00);
    do_wr(8'h99);                       // lands at 0x201
    rd_expect("R4 prefetch kept over write", 8'h11);
    rd_expect("R4 next after write", 8'h33);
    do_set(13'h0201);
    rd_expect("R4 dummy 2", 8'h00);
    rd_expect("R4 written byte visible", 8'h99);
  endtask

  // R5: wrap at the top of the address range
  task automatic t_wrap();
    do_set(13'h1FFF);
    do_wr(8'h5A);
    do_wr(8'hC3);                       // wrapped to 0x0000
    do_set(13'h1FFF);
    rd_expect("R5 dummy", 8'h00);
    rd_expect("R5 last address", 8'h5A);
    rd_expect("R5 wrapped to zero", 8'hC3);
  endtask

  // R7: coinciding strobes
  task automatic t_prio();
    do_set(13'h0300);
    do_wr(8'h01); do_wr(8'h02); do_wr(8'h03);
    do_set(13'h0300);
    rd_expect("R7 prime", 8'h00);       // prefetch now 0x01, addr 0x301
    @(negedge clk);
    set_addr_stb = 1'b1; set_addr_val = 13'h0300;
    wr_stb = 1'b1; wr_data = 8'hEE; rd_stb = 1'b1;
    @(negedge clk);
    set_addr_stb = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    chk("R7 set beats read (no valid)", {7'd0, rd_valid}, 8'h00);
    rd_expect("R7 set cleared prefetch", 8'h00);
    rd_expect("R7 write lost to set", 8'h01);
    rd_expect("R7 next byte", 8'h02);   // addr now 0x303
    do_set(13'h0302);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h77; rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    chk("R7 write beats read (no valid)", {7'd0, rd_valid}, 8'h00);
    do_set(13'h0302);
    rd_expect("R7 dummy", 8'h00);
    rd_expect("R7 write landed", 8'h77);
  endtask

  // R6: output holds between reads
  task automatic t_hold();
    logic [7:0] v; logic vl;
    do_set(13'h0100);
    rd_expect("R6 dummy", 8'h00);
    do_rd(v, vl);
    repeat (4) @(negedge clk);
    chk("R6 rd_data held", rd_data, pat(0));
    chk("R6 rd_valid idle", {7'd0, rd_valid}, 8'h00);
  endtask

  // R8, R1: memory survives reset
  task automatic t_noclear();
    do_set(13'h0400);
    do_wr(8'h4D);
    do_set(13'h0400);
    rd_expect("R8 prime", 8'h00);       // prefetch now 0x4D
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 rd_valid after second reset", {7'd0, rd_valid}, 8'h00);
    rd_expect("R1 prefetch cleared by reset", 8'h00);
    do_set(13'h0400);
    rd_expect("R8 dummy", 8'h00);
    rd_expect("R8 memory kept", 8'h4D);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_aa();
    t_stream();
    t_write_pend();
    t_wrap();
    t_prio();
    t_hold();
    t_noclear();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule